// File: doc/BRIEF.md
# Mode-Selectable Inverting Bus Transceiver

This block is a bidirectional transceiver between a three-state A port and an open-collector, wired-OR style B port. The datapath width is a parameter and defaults to nine bits. Every bit is handled the same way and in parallel. Each direction has a storage stage that presents one of three sources: a transparent latch, an edge-triggered register, or the raw input. A two-bit mode select chooses the source for both directions together. The value presented at the far side is always the bitwise inverse of that source.

Each direction has its own clock input. In register mode this input is an edge clock. In latch mode it is an active-low latch enable. Output-enable logic gates the two sides independently. A power-good input holds the B drivers released while supply is invalid.

Ports are modelled as separate input, output and enable signals. The B side is given as a per-bit pull-down request, and a request is raised only for a bit whose inverted value is 0.

Top module: `xcvr_inv_top`

## Requirements
- R1: With `mode_sel` = 2'b00 both directions present their latch contents.
- R2: With `mode_sel` = 2'b01 both directions present their register contents. Each register loads its direction's input on the rising edge of that direction's clock (`clk_ab` for A-to-B, `clk_ba` for B-to-A).
- R3: With `mode_sel` = 2'b10 both directions pass their input straight through, with no storage in the path.
- R4: With `mode_sel` = 2'b11 the A-to-B direction presents its register and the B-to-A direction presents its latch.
- R5: Each latch follows its input while its direction's clock is 0 and holds its value while the clock is 1.
- R6: In every mode, the value a direction presents is the bitwise inverse of its selected source.
- R7: `a_oe` equals `oe_a`. `a_out` always carries the B-to-A value, whatever the enable.
- R8: B drives only when `oe_b_hi`=1, `oe_b_lo`=0 and `pwr_ok`=1. Bit i of `b_pull` is then 1 exactly when bit i of the inverted A-to-B value is 0. Under any other enable combination `b_pull` is all zeros.
- R9: While `pwr_ok`=0, `b_pull` is all zeros whatever the other enables.
- R10: Output enables have no effect on storage. Registers and latches load and hold while their outputs are disabled.
- R11: While `rst_n`=0 both registers are cleared to zero, so in register mode `a_out` is all ones and `b_pull` is all zeros. The latches are not reset.
- R12: The registers and latches update in every mode. Switching modes presents whatever the newly chosen source already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| mode_sel | input | 2 | Storage mode for both directions |
| clk_ab | input | 1 | A-to-B edge clock / active-low latch enable |
| clk_ba | input | 1 | B-to-A edge clock / active-low latch enable |
| oe_a | input | 1 | A side drive enable, active high |
| oe_b_hi | input | 1 | B side enable, must be 1 to drive |
| oe_b_lo | input | 1 | B side enable, must be 0 to drive |
| pwr_ok | input | 1 | Supply valid; 0 forces B released |
| a_in | input | WIDTH | Level seen on the A lines |
| a_out | output | WIDTH | Value for the A drivers |
| a_oe | output | 1 | A driver enable |
| b_in | input | WIDTH | Resolved level on the B bus lines |
| b_pull | output | WIDTH | Per-bit pull-down request on the B lines |

## Verification
Only the register outputs depend on an edge. A register value is due just after the rising clock edge of its own direction. The pass, latch and enable paths are combinational and are due as soon as an input changes. The bench changes one group of inputs at a time and waits half a clock period before it compares. It updates its reference registers from the input values present just before each rising edge, and its reference latches only while the matching clock is low. The checker samples on rising clock edges, where a latch's enable is still low and the previous register load is already visible.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      PATH_LATCH = 2'd0,
      PATH_REG   = 2'd1,
      PATH_PASS  = 2'd2
   } path_mode_e;

   localparam logic [1:0] SEL_ALL_LATCH = 2'b00;
   localparam logic [1:0] SEL_ALL_REG   = 2'b01;
   localparam logic [1:0] SEL_ALL_PASS  = 2'b10;
   localparam logic [1:0] SEL_MIXED     = 2'b11;

endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
   import xcvr_pkg::*;
(
   input  logic [1:0] mode_sel,
   output path_mode_e ab_mode,
   output path_mode_e ba_mode
);

   always_comb begin
      unique case (mode_sel)
         SEL_ALL_LATCH: begin ab_mode = PATH_LATCH; ba_mode = PATH_LATCH; end
         SEL_ALL_REG:   begin ab_mode = PATH_REG;   ba_mode = PATH_REG;   end
         SEL_ALL_PASS:  begin ab_mode = PATH_PASS;  ba_mode = PATH_PASS;  end
         default:       begin ab_mode = PATH_REG;   ba_mode = PATH_LATCH; end
      endcase
   end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 9
) (
   input  logic             rst_n,
   input  logic             le_clk,
   input  path_mode_e       mode,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] val
);

   logic [WIDTH-1:0] reg_q;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] src;

   // register loads in every mode; mode only picks what is shown
   always_ff @(posedge le_clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= d;
   end

   // transparent while enable low, not reset
   always_latch begin
      if (!le_clk) lat_q <= d;
   end

   always_comb begin
      unique case (mode)
         PATH_PASS: src = d;
         PATH_REG:  src = reg_q;
         default:   src = lat_q;
      endcase
   end

   assign val = ~src;

endmodule

// File: rtl/xcvr_drv.sv
module xcvr_drv #(
   parameter int WIDTH = 9
) (
   input  logic             oe_a,
   input  logic             oe_b_hi,
   input  logic             oe_b_lo,
   input  logic             pwr_ok,
   input  logic [WIDTH-1:0] ab_val,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_pull
);

   logic b_drive;

   assign b_drive = pwr_ok & oe_b_hi & ~oe_b_lo;
   assign a_oe    = oe_a;

   // open-collector: pull low only for a driven zero
   for (genvar i = 0; i < WIDTH; i++) begin : g_pull
      assign b_pull[i] = b_drive & ~ab_val[i];
   end

endmodule

// File: rtl/xcvr_inv_top.sv
module xcvr_inv_top
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 9
) (
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             oe_a,
   input  logic             oe_b_hi,
   input  logic             oe_b_lo,
   input  logic             pwr_ok,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_pull
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_inv_top: WIDTH must be at least 1");
   end

   path_mode_e       ab_mode;
   path_mode_e       ba_mode;
   logic [WIDTH-1:0] ab_val;
   logic [WIDTH-1:0] ba_val;

   xcvr_mode_dec u_dec (
      .mode_sel (mode_sel),
      .ab_mode  (ab_mode),
      .ba_mode  (ba_mode)
   );

   xcvr_path #(.WIDTH(WIDTH)) u_ab (
      .rst_n  (rst_n),
      .le_clk (clk_ab),
      .mode   (ab_mode),
      .d      (a_in),
      .val    (ab_val)
   );

   xcvr_path #(.WIDTH(WIDTH)) u_ba (
      .rst_n  (rst_n),
      .le_clk (clk_ba),
      .mode   (ba_mode),
      .d      (b_in),
      .val    (ba_val)
   );

   xcvr_drv #(.WIDTH(WIDTH)) u_drv (
      .oe_a    (oe_a),
      .oe_b_hi (oe_b_hi),
      .oe_b_lo (oe_b_lo),
      .pwr_ok  (pwr_ok),
      .ab_val  (ab_val),
      .a_oe    (a_oe),
      .b_pull  (b_pull)
   );

   assign a_out = ba_val;

endmodule

// File: rtl/xcvr_inv_chk.sv
module xcvr_inv_chk
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 9
) (
   input logic             rst_n,
   input logic             clk_ab,
   input logic             clk_ba,
   input logic [1:0]       mode_sel,
   input logic             oe_b_hi,
   input logic             oe_b_lo,
   input logic             pwr_ok,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] b_pull,
   input logic [WIDTH-1:0] ab_val
);

   // set once a full edge has passed out of reset
   logic armed_ab;
   always_ff @(posedge clk_ab or negedge rst_n) begin
      if (!rst_n) armed_ab <= 1'b0;
      else        armed_ab <= 1'b1;
   end

   assert_reg_capture_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (armed_ab && $past(mode_sel) == SEL_ALL_REG && mode_sel == SEL_ALL_REG)
         |-> ab_val == ~$past(a_in));

   assert_pass_ab_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (mode_sel == SEL_ALL_PASS) |-> ab_val == ~a_in);

   assert_mixed_ba_latch_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (mode_sel == SEL_MIXED) |-> a_out == ~b_in);

   assert_latch_open_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (mode_sel == SEL_ALL_LATCH) |-> ab_val == ~a_in);

   assert_b_quiet_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !(oe_b_hi && !oe_b_lo) |-> b_pull == '0);

   assert_no_pull_unpowered_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !pwr_ok |-> b_pull == '0);

endmodule

bind xcvr_inv_top xcvr_inv_chk #(.WIDTH(WIDTH)) u_chk (
   .rst_n    (rst_n),
   .clk_ab   (clk_ab),
   .clk_ba   (clk_ba),
   .mode_sel (mode_sel),
   .oe_b_hi  (oe_b_hi),
   .oe_b_lo  (oe_b_lo),
   .pwr_ok   (pwr_ok),
   .a_in     (a_in),
   .b_in     (b_in),
   .a_out    (a_out),
   .b_pull   (b_pull),
   .ab_val   (ab_val)
);

// File: tb/tb_xcvr_inv_top.sv
module tb_xcvr_inv_top;

   localparam int W          = 9;
   localparam int CLK_PERIOD = 10;

   logic         rst_n;
   logic [1:0]   mode_sel;
   logic         clk_ab, clk_ba;
   logic         oe_a, oe_b_hi, oe_b_lo, pwr_ok;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_pull;
   logic         a_oe;

   logic [W-1:0] m_reg_ab, m_reg_ba, m_lat_ab, m_lat_ba;
   int checks = 0;
   int errors = 0;

   xcvr_inv_top #(.WIDTH(W)) dut (
      .rst_n(rst_n), .mode_sel(mode_sel), .clk_ab(clk_ab), .clk_ba(clk_ba),
      .oe_a(oe_a), .oe_b_hi(oe_b_hi), .oe_b_lo(oe_b_lo), .pwr_ok(pwr_ok),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_pull(b_pull)
   );

   task automatic settle();
      #(CLK_PERIOD/2);
   endtask

   task automatic track();
      if (!clk_ab) m_lat_ab = a_in;
      if (!clk_ba) m_lat_ba = b_in;
   endtask

   task automatic set_data(input logic [W-1:0] a, input logic [W-1:0] b);
      a_in = a; b_in = b; track(); settle();
   endtask

   task automatic drop();
      clk_ab = 1'b0; clk_ba = 1'b0; track(); settle();
   endtask

   task automatic rise();
      m_reg_ab = a_in; m_reg_ba = b_in;
      clk_ab = 1'b1; clk_ba = 1'b1; settle();
   endtask

   task automatic set_oe(input logic [3:0] e);
      {oe_a, oe_b_hi, oe_b_lo, pwr_ok} = e; settle();
   endtask

   task automatic one(input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check(input string tag);
      logic [W-1:0] ab_src, ba_src, exp_b;
      case (mode_sel)
         2'b10:        ab_src = a_in;
         2'b01, 2'b11: ab_src = m_reg_ab;
         default:      ab_src = m_lat_ab;
      endcase
      case (mode_sel)
         2'b10:   ba_src = b_in;
         2'b01:   ba_src = m_reg_ba;
         default: ba_src = m_lat_ba;
      endcase
      // pull request is raised where the inverted value is 0, i.e. source bit 1
      exp_b = (oe_b_hi && !oe_b_lo && pwr_ok) ? ab_src : '0;
      one({tag, " R6"}, "a_out", a_out, ~ba_src);
      one({tag, " R8"}, "b_pull", b_pull, exp_b);
      one({tag, " R7"}, "a_oe", W'(a_oe), W'(oe_a));
   endtask

   function automatic string mode_tag(input int m);
      case (m)
         0:       return "R1";
         1:       return "R2";
         2:       return "R3";
         default: return "R4";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD*150000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode_sel = 2'b01;
      clk_ab = 1'b1; clk_ba = 1'b1;
      a_in = 9'h1A5; b_in = 9'h0F3;
      m_reg_ab = '0; m_reg_ba = '0; m_lat_ab = '0; m_lat_ba = '0;
      set_oe(4'b1101);
      // R11: registers cleared, so a_out all ones and no pulls
      check("R11");
      one("R11", "a_out", a_out, '1);
      one("R11", "b_pull", b_pull, '0);
      rst_n = 1'b1; settle();
      drop(); rise();
      check("R2");

      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 6; p++) begin
            logic [W-1:0] pa, pb;
            pa = W'(p*53 + m*97 + 5);
            pb = W'(p*211 + m*29 + 300);
            mode_sel = 2'(m);
            set_oe(4'b1101);
            set_data(pa, pb);
            check({mode_tag(m), " R12"});
            drop();
            check({mode_tag(m), " R5 open"});
            set_data(~pa, pb ^ 9'h155);
            check({mode_tag(m), " R5 follow"});
            rise();
            check(mode_tag(m));
            set_data(pb, pa);
            check({mode_tag(m), " R5 hold"});
            for (int e = 0; e < 16; e++) begin
               set_oe(4'(e));
               check(pwr_ok ? "R8" : "R9");
            end
            // R10: load while every output is disabled
            set_oe(4'b0010);
            set_data(pa ^ pb, ~pb);
            drop();
            set_data(pa + 9'd7, pb - 9'd3);
            rise();
            set_oe(4'b1101);
            check("R10");
         end
      end

      // R12: storage keeps updating in pass mode, then is exposed
      mode_sel = 2'b10;
      set_data(9'h0C3, 9'h13C);
      drop(); rise();
      set_data(9'h1FF, 9'h000);
      check("R12 R3");
      mode_sel = 2'b01; settle();
      check("R12 R2");
      one("R12", "b_pull", b_pull, 9'h0C3);
      mode_sel = 2'b00; settle();
      check("R12 R1");
      mode_sel = 2'b11; settle();
      check("R12 R4");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule